// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit sits in the execute stage of a 32-bit processor. It takes two operands, `op_a` and `op_b`, a carry input and a 2-bit opcode, and it returns one result word. There are four functions. The two compare functions return the difference `op_b - op_a`. The most significant bit of that difference is then adjusted, so that the MSB alone tells whether `op_a` is greater than `op_b`, in signed or in unsigned terms. The low bits still hold the raw difference.

The carry function returns the carry-out of `op_a + op_b + carry_in`, zero-extended to a full word. The byte-match function scans the byte lanes from the most significant lane downward. It reports the position of the first lane in which both operands hold the same byte.

The datapath is combinational. An output register can be added by setting the parameter `REG_OUT` (default 1); it then adds one clock of latency.

Top module: `cmp_match_unit`

## Requirements
- R1: For opcode 00 (signed compare) and opcode 01 (unsigned compare), bits [DW-2:0] of the result equal bits [DW-2:0] of `op_b - op_a`, taken modulo 2^DW.
- R2: For opcode 00, result bit DW-1 is 1 exactly when `op_a` is greater than `op_b` as two's-complement numbers. When the operand sign bits differ, this bit is the sign bit of `op_b`.
- R3: For opcode 01, result bit DW-1 is 1 exactly when `op_a` is greater than `op_b` as unsigned numbers. When the operand MSBs differ, this bit is the MSB of `op_a`.
- R4: For opcode 10, result bit 0 is the carry-out of `op_a + op_b + carry_in`, and all other result bits are 0.
- R5: For opcode 11, byte lanes are numbered 1 for bits [31:24], 2 for [23:16], 3 for [15:8] and 4 for [7:0]. The result is the number of the lowest-numbered lane whose bytes are equal in both operands, so the most significant matching lane wins.
- R6: For opcode 11, the result is 0 when no byte lane matches.
- R7: With `REG_OUT`=1, the result for inputs presented before a rising clock edge appears after that edge, and the output register reads 0 while reset is asserted.
- R8: `carry_in` has no effect on the result for opcodes 00, 01 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | DW | First operand (the subtrahend in compares) |
| op_b | input | DW | Second operand |
| carry_in | input | 1 | Carry input for the carry function |
| opcode | input | 2 | Function select: 00 signed compare, 01 unsigned compare, 10 carry, 11 byte match |
| result | output | DW | Function result |

## Verification
The compare functions are driven with operands of equal sign, operands of opposite sign, equal operands, and the extremes of each range. Opposite-sign pairs are what separate the signed patch from the unsigned patch, and from a bare subtraction. The carry function is tried with an all-ones operand plus a carry, with a large sum that produces no carry, and with a zero carry input, so that each term of the carry condition is tested on its own. The byte search uses operands that match in only one lane, operands that match in several lanes, and operands that match in none. This shows whether the scan order is right and whether the no-match value is 0.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    OP_SCMP   = 2'b00,
    OP_UCMP   = 2'b01,
    OP_CARRY  = 2'b10,
    OP_BMATCH = 2'b11
  } cmu_op_e;
endpackage

// File: rtl/cmu_ordered_sub.sv
// Subtraction b - a whose top bit is patched to carry the ordering a > b.
module cmu_ordered_sub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          is_signed,
  output logic [DW-1:0] res
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] diff;
  logic          sign_split;
  logic          top_bit;

  always_comb begin
    diff       = b - a;
    sign_split = a[MSB] ^ b[MSB];
    if (sign_split) top_bit = is_signed ? b[MSB] : a[MSB];
    else            top_bit = diff[MSB];
    res = {top_bit, diff[MSB-1:0]};
  end
endmodule

// File: rtl/cmu_carry_gen.sv
// Carry-out of a + b + cin.
module cmu_carry_gen #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic          cout
);
  logic [DW:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    cout     = wide_sum[DW];
  end
endmodule

// File: rtl/cmu_byte_scan.sv
// First equal byte lane, counted from the most significant end (1-based).
module cmu_byte_scan #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int IDX_W = $clog2(LANES + 1)
) (
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [IDX_W-1:0] lane_idx
);
  logic [LANES-1:0] lane_eq;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      localparam int HI = DW - 1 - 8 * g;
      assign lane_eq[g] = (a[HI -: 8] == b[HI -: 8]);
    end
  endgenerate

  always_comb begin
    lane_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_eq[i]) lane_idx = IDX_W'(i + 1);
    end
  end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  input  logic [1:0]    opcode,
  output logic [DW-1:0] result
);
  import cmu_pkg::*;

  localparam int LANES = DW / 8;
  localparam int IDX_W = $clog2(LANES + 1);

  cmu_op_e         op;
  logic [DW-1:0]   cmp_res;
  logic            carry_res;
  logic [IDX_W-1:0] match_res;
  logic [DW-1:0]   res_nxt;

  assign op = cmu_op_e'(opcode);

  cmu_ordered_sub #(.DW(DW)) u_sub (
    .a         (op_a),
    .b         (op_b),
    .is_signed (op == OP_SCMP),
    .res       (cmp_res)
  );

  cmu_carry_gen #(.DW(DW)) u_carry (
    .a    (op_a),
    .b    (op_b),
    .cin  (carry_in),
    .cout (carry_res)
  );

  cmu_byte_scan #(.DW(DW), .LANES(LANES), .IDX_W(IDX_W)) u_scan (
    .a        (op_a),
    .b        (op_b),
    .lane_idx (match_res)
  );

  always_comb begin
    unique case (op)
      OP_SCMP, OP_UCMP: res_nxt = cmp_res;
      OP_CARRY:         res_nxt = {{(DW-1){1'b0}}, carry_res};
      OP_BMATCH:        res_nxt = {{(DW-IDX_W){1'b0}}, match_res};
      default:          res_nxt = '0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [DW-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_nxt;
      end
      assign result = res_q;
    end else begin : g_comb
      assign result = res_nxt;
    end
  endgenerate
endmodule

// File: rtl/cmu_checker.sv
module cmu_checker #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          carry_in,
  input logic [1:0]    opcode,
  input logic [DW-1:0] result
);
  localparam int LANES = DW / 8;
  localparam int MSB   = DW - 1;

  logic [DW-1:0] a_v, b_v;
  logic          c_v;
  logic [1:0]    o_v;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_v <= '0; b_v <= '0; c_v <= 1'b0; o_v <= 2'b00;
        end else begin
          a_v <= op_a; b_v <= op_b; c_v <= carry_in; o_v <= opcode;
        end
      end
    end else begin : g_now
      always_comb begin
        a_v = op_a; b_v = op_b; c_v = carry_in; o_v = opcode;
      end
    end
  endgenerate

  logic [DW-1:0] sub_v;
  logic [DW:0]   sum_v;
  logic          none_eq;

  always_comb begin
    sub_v   = b_v - a_v;
    sum_v   = {1'b0, a_v} + {1'b0, b_v} + {{DW{1'b0}}, c_v};
    none_eq = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (a_v[8*i +: 8] == b_v[8*i +: 8]) none_eq = 1'b0;
    end
  end

  a_r1_low_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v[1] == 1'b0) |-> (result[MSB-1:0] == sub_v[MSB-1:0]));

  a_r2_signed_order: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v == 2'b00) |-> (result[MSB] == ($signed(a_v) > $signed(b_v))));

  a_r3_unsigned_order: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v == 2'b01) |-> (result[MSB] == (a_v > b_v)));

  a_r4_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v == 2'b10) |-> (result == {{(DW-1){1'b0}}, sum_v[DW]}));

  a_r5_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v == 2'b11) |-> (result <= DW'(LANES)));

  a_r6_no_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v == 2'b11 && none_eq) |-> (result == '0));
endmodule

bind cmp_match_unit cmu_checker #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .opcode   (opcode),
  .result   (result)
);

// File: tb/cmp_match_unit_tb.sv
module cmp_match_unit_tb;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] op_a, op_b;
  logic          carry_in;
  logic [1:0]    opcode;
  logic [DW-1:0] result;

  int total = 0;
  int bad   = 0;

  cmp_match_unit #(.DW(DW), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .opcode(opcode), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] ref_cmp(input logic [31:0] a, input logic [31:0] b,
                                          input bit sgn);
    logic [31:0] d;
    bit gt;
    d  = b - a;
    gt = sgn ? ($signed(a) > $signed(b)) : (a > b);
    return {gt, d[30:0]};
  endfunction

  function automatic logic [31:0] ref_carry(input logic [31:0] a, input logic [31:0] b,
                                            input logic c);
    longint unsigned s;
    s = longint'(a) + longint'(b) + longint'(c);
    return {31'd0, s[32]};
  endfunction

  function automatic logic [31:0] ref_match(input logic [31:0] a, input logic [31:0] b);
    if (a[31:24] == b[31:24]) return 32'd1;
    if (a[23:16] == b[23:16]) return 32'd2;
    if (a[15:8]  == b[15:8])  return 32'd3;
    if (a[7:0]   == b[7:0])   return 32'd4;
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at a falling edge; the register loads at the next rising edge; sample at the next falling edge.
  task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic c);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    opcode = 2'b10; op_a = 32'hFFFF_FFFF; op_b = 32'h1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset clears output", result, 32'h0);
    rst_n = 1'b1;
    apply(2'b10, 32'hFFFF_FFFF, 32'h1, 1'b1);
    check("R7 registered result after one edge", result, 32'h1);
  endtask

  task automatic t_signed;
    logic [31:0] av [5] = '{32'h0000_0005, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFE};
    logic [31:0] bv [5] = '{32'h0000_0009, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h0000_0003};
    for (int i = 0; i < 5; i++) begin
      apply(2'b00, av[i], bv[i], 1'b0);
      check("R1/R2 signed compare", result, ref_cmp(av[i], bv[i], 1'b1));
    end
  endtask

  task automatic t_unsigned;
    logic [31:0] av [5] = '{32'h0000_0009, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE};
    logic [31:0] bv [5] = '{32'h0000_0005, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0003};
    for (int i = 0; i < 5; i++) begin
      apply(2'b01, av[i], bv[i], 1'b0);
      check("R1/R3 unsigned compare", result, ref_cmp(av[i], bv[i], 1'b0));
    end
  endtask

  task automatic t_carry;
    apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    check("R4 all-ones plus carry", result, ref_carry(32'h0, 32'hFFFF_FFFF, 1'b1));
    apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    check("R4 all-ones without carry", result, 32'h0);
    apply(2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R4 top bits overflow", result, 32'h1);
    apply(2'b10, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
    check("R4 largest sum without carry", result, ref_carry(32'h7FFF_FFFF, 32'h8000_0000, 1'b0));
  endtask

  task automatic t_match;
    apply(2'b11, 32'hAA11_2233, 32'hAA99_8877, 1'b0);
    check("R5 top lane", result, 32'd1);
    apply(2'b11, 32'h0011_2233, 32'hFF11_FF33, 1'b0);
    check("R5 several lanes, top-most wins", result, ref_match(32'h0011_2233, 32'hFF11_FF33));
    apply(2'b11, 32'h0102_0344, 32'hF0F1_0355, 1'b0);
    check("R5 third lane", result, 32'd3);
    apply(2'b11, 32'h0102_0344, 32'hF0F1_F244, 1'b0);
    check("R5 bottom lane", result, 32'd4);
    apply(2'b11, 32'h0102_0304, 32'h1020_3040, 1'b0);
    check("R6 no lane matches", result, 32'd0);
  endtask

  task automatic t_cin_ignored;
    apply(2'b00, 32'h0000_0010, 32'h0000_0004, 1'b1);
    check("R8 carry_in ignored for signed compare", result, ref_cmp(32'h10, 32'h4, 1'b1));
    apply(2'b01, 32'h8000_0001, 32'h0000_0004, 1'b1);
    check("R8 carry_in ignored for unsigned compare", result, ref_cmp(32'h8000_0001, 32'h4, 1'b0));
    apply(2'b11, 32'h0102_0304, 32'h1020_3040, 1'b1);
    check("R8 carry_in ignored for byte match", result, 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_signed();
    t_unsigned();
    t_carry();
    t_match();
    t_cin_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule